// File: doc/BRIEF.md
# Address region security filter

This block sits beside a memory-side bus port and decides, for every access, whether the access may proceed and how its data must be treated. Software programs up to four address windows. Each window has an inclusive start page and an inclusive end page at 4 KB granularity, a privileged-only flag, a write-enable attribute, a cipher selection and a context number. An address that falls in no enabled window belongs to a default region. The default region grants everything and applies no cipher.

When an address falls in two windows, the one that is encrypted sets the rules. Two encrypted windows that overlap cause a rejection, and among unencrypted windows the lowest index wins. The chosen cipher drops back to bypass when the key or context it needs is not valid. The decision is registered once, so it appears on the cycle after the address. A violating access sets a bus-error flag and records its address, direction and privilege. Wrong-privilege configuration accesses set a separate flag. Both flags feed one maskable interrupt line.

Configuration map, byte offsets: 0x00 control (bit0 lock, bit1 privileged-only configuration), 0x04 flags (bit0 configuration error, bit1 bus error), 0x08 write-one-to-clear for the flags, 0x0C interrupt enables (same bit order), 0x10 error info (bit0 write, bit1 privileged), 0x14 error address. Window r sits at 0x20+0x10·r: +0 control (bit0 enable, bit4 privileged-only, bits 9:8 cipher, bits 13:12 context), +4 start, +8 end, +C attribute (bit0 write-enable).

Top module: `rgn_guard`

## Requirements
- R1: An access hits window r when r is enabled and address bits 27:12 lie between the start and end pages, both bounds included. Address bits 31:28 and 11:0 play no part in the comparison.
- R2: Start reads back with bits 27:12 as written and all other bits zero. End reads back with bits 27:12 as written, bits 11:0 all ones and bits 31:28 zero. After reset, start reads 0x00000000 and end reads 0x00000FFF.
- R3: Writing enable=1 to a window control word leaves the window disabled when its start page is above its end page.
- R4: An access that hits no enabled window is granted with cipher code 00 and context 0.
- R5: When an access hits several windows, a single encrypted hit supplies the rules. Two or more encrypted hits reject the access. With no encrypted hit, the lowest-indexed window supplies the rules.
- R6: A write to the ruling window with write-enable clear is rejected. An unprivileged access to a privileged-only ruling window is rejected. A rejected access reports grant=0 with cipher 00 and context 0.
- R7: Cipher codes are 00 none, 01 stream, 10 block and 11 fast block. The output is 00 with context 0 in four cases: stream with context 0; block with context 0 and the main key invalid; fast block with context 0 and the fast key invalid; a nonzero context that is reserved (3) or whose ctx_ok bit (bit k-1 for context k) is low.
- R8: While a window is enabled, writes to its start, end, cipher and context fields are ignored. Its privileged-only bit, its write-enable bit and its enable bit still take writes.
- R9: Once the lock bit is set it stays set until reset. From then on every configuration write is ignored except writes to the flag-clear and interrupt-enable registers.
- R10: A rejection for a write or privilege violation, or for an encrypted overlap, sets the bus-error flag and records the address, direction and privilege. The record stays unchanged until software clears the flag.
- R11: A configuration access with the wrong privilege, made while privileged-only configuration is set, reads zero, is ignored and sets the configuration-error flag. irq is the OR of each flag ANDed with its enable. Writing 1 to a clear bit clears that flag.
- R12: While cipher_off is high, an access whose ruling window has a nonzero cipher code is rejected. The default region stays granted.
- R13: dec_valid and the decision fields are registered. They reflect the access presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | Configuration write (1) or read (0) |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_priv | input | 1 | Configuration access is privileged |
| cfg_rdata | output | 32 | Configuration read data, same cycle |
| key_main_ok | input | 1 | Main key is valid |
| key_fast_ok | input | 1 | Fast key is valid |
| ctx_ok | input | 2 | Context-enable bits for contexts 1 and 2 |
| cipher_off | input | 1 | Encryption disabled status |
| acc_valid | input | 1 | Bus access present |
| acc_addr | input | 32 | Bus access address |
| acc_write | input | 1 | Bus access is a write |
| acc_priv | input | 1 | Bus access is privileged |
| dec_valid | output | 1 | Decision valid |
| dec_grant | output | 1 | Access granted |
| dec_mode | output | 2 | Cipher code applied |
| dec_ctx | output | 2 | Context number applied |
| irq | output | 1 | Combined maskable interrupt |

## Verification
The bench targets the overlap corners. If the design picked the highest index among unencrypted windows, it would reject a write that the lower window allows. If it let one of two encrypted windows win, it would grant an access that must be refused. Addresses on the first and last byte of a window and an address with the top nibble set catch off-by-one bounds and a comparison that is too wide. Key and context fallback, the freeze of enabled windows, the lock, and an error record that a second violation must not overwrite each have a directed test. A design that got any of these wrong would change grant, mode or a readback value at the ports.

// File: rtl/rgn_pkg.sv
// Shared types for the address region security filter.
// Assumes the context field is two bits wide (context 0 plus up to three others).
package rgn_pkg;
    localparam int CTX_W = 2;

    typedef enum logic [1:0] {
        ENC_NONE   = 2'b00,
        ENC_STREAM = 2'b01,
        ENC_BLOCK  = 2'b10,
        ENC_FAST   = 2'b11
    } enc_e;

    typedef struct packed {
        logic             en;
        logic             priv;
        logic             wren;
        enc_e             enc;
        logic [CTX_W-1:0] ctx;
    } rgn_cfg_t;
endpackage

// File: rtl/rgn_match.sv
// Inclusive page-range comparator for one window.
// Assumes the caller has already sliced the page field out of the address.
module rgn_match #(
    parameter int PW = 16
) (
    input  logic          en,
    input  logic [PW-1:0] page,
    input  logic [PW-1:0] lo,
    input  logic [PW-1:0] hi,
    output logic          hit
);
    // Hit when enabled and lo <= page <= hi.
    always_comb hit = en && (page >= lo) && (page <= hi);
endmodule

// File: rtl/rgn_resolve.sv
// Picks the ruling window among the hits, applies the permission checks and
// settles the cipher mode with its key and context fallback.
// Assumes the context numbers 1..NCTX map onto ctx_ok[0..NCTX-1].
module rgn_resolve
    import rgn_pkg::*;
#(
    parameter int NREG = 4,
    parameter int NCTX = 2
) (
    input  logic [NREG-1:0]     hit,
    input  rgn_cfg_t [NREG-1:0] rcfg,
    input  logic                acc_write,
    input  logic                acc_priv,
    input  logic                key_main_ok,
    input  logic                key_fast_ok,
    input  logic [NCTX-1:0]     ctx_ok,
    input  logic                cipher_off,
    output logic                grant,
    output logic                viol,
    output enc_e                mode,
    output logic [CTX_W-1:0]    ctx
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int CW = $clog2(NREG + 1);

    logic [CW-1:0] enc_cnt;
    logic [IW-1:0] enc_sel, plain_sel, sel;
    logic          key_ok, ctx_valid;
    rgn_cfg_t      c;

    // Count encrypted hits and find the lowest encrypted and lowest overall hit.
    always_comb begin
        enc_cnt   = '0;
        enc_sel   = '0;
        plain_sel = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit[i]) begin
                plain_sel = IW'(i);
                if (rcfg[i].enc != ENC_NONE) begin
                    enc_sel = IW'(i);
                    enc_cnt = enc_cnt + 1'b1;
                end
            end
        end
        sel = (enc_cnt != '0) ? enc_sel : plain_sel;
        c   = rcfg[sel];
    end

    // Validity of the key or context the ruling window selects.
    always_comb begin
        ctx_valid = 1'b0;
        for (int k = 1; k <= NCTX; k++)
            if (c.ctx == CTX_W'(k)) ctx_valid = ctx_ok[k-1];
        if (c.ctx == '0) begin
            case (c.enc)
                ENC_BLOCK: key_ok = key_main_ok;
                ENC_FAST:  key_ok = key_fast_ok;
                default:   key_ok = 1'b0;
            endcase
        end else begin
            key_ok = ctx_valid;
        end
    end

    // Final grant, violation and mode decision.
    always_comb begin
        grant = 1'b1;
        viol  = 1'b0;
        mode  = ENC_NONE;
        ctx   = '0;
        if (hit != '0) begin
            if (enc_cnt > CW'(1)) begin
                grant = 1'b0;
                viol  = 1'b1;
            end else if ((acc_write && !c.wren) || (c.priv && !acc_priv)) begin
                grant = 1'b0;
                viol  = 1'b1;
            end else if (c.enc != ENC_NONE && cipher_off) begin
                grant = 1'b0;
            end else if (c.enc != ENC_NONE && key_ok) begin
                mode = c.enc;
                ctx  = c.ctx;
            end
        end
    end
endmodule

// File: rtl/rgn_regs.sv
// Configuration register file: window setup with freeze and lock rules, error
// flags with the captured violation record, and the interrupt combine.
// Assumes cfg data width equals the bus address width (AW).
module rgn_regs
    import rgn_pkg::*;
#(
    parameter int NREG = 4,
    parameter int AW   = 32,
    parameter int PLO  = 12,
    parameter int PW   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_req,
    input  logic                  cfg_we,
    input  logic [7:0]            cfg_addr,
    input  logic [AW-1:0]         cfg_wdata,
    input  logic                  cfg_priv,
    output logic [AW-1:0]         cfg_rdata,
    input  logic                  bus_evt,
    input  logic [AW-1:0]         evt_addr,
    input  logic                  evt_write,
    input  logic                  evt_priv,
    output rgn_cfg_t [NREG-1:0]   rcfg_o,
    output logic [NREG-1:0][PW-1:0] lo_o,
    output logic [NREG-1:0][PW-1:0] hi_o,
    output logic                  irq,
    output logic                  lock_o,
    output logic                  bus_flag_o,
    output logic                  bus_clr_o,
    output logic [AW-1:0]         err_addr_o
);
    localparam logic [7:0] A_CTRL = 8'h00, A_FLAG = 8'h04, A_CLR = 8'h08;
    localparam logic [7:0] A_IEN  = 8'h0C, A_INFO = 8'h10, A_EADR = 8'h14;
    localparam int RB = 2;

    rgn_cfg_t [NREG-1:0]     rcfg_q;
    logic [NREG-1:0][PW-1:0] lo_q, hi_q;
    logic          lock_q, ponly_q, cflag_q, bflag_q, ev_wr_q, ev_pr_q;
    logic [1:0]    ie_q, clr;
    logic [AW-1:0] err_addr_q;
    logic          priv_ok, acc_ok, wr, wr_cfg;
    logic [NREG-1:0] rsel;
    logic          unused_w;

    // Access qualification and window selection.
    always_comb begin
        priv_ok = !ponly_q || cfg_priv;
        acc_ok  = cfg_req && priv_ok;
        wr      = acc_ok && cfg_we;
        wr_cfg  = wr && !lock_q;
        clr     = (wr && cfg_addr == A_CLR) ? cfg_wdata[1:0] : 2'b00;
        for (int i = 0; i < NREG; i++) rsel[i] = (cfg_addr[7:4] == 4'(i + RB));
    end
    assign unused_w = ^{cfg_wdata, cfg_addr[1:0]};

    // Global control, flags and the violation record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0; ponly_q <= 1'b0; cflag_q <= 1'b0; bflag_q <= 1'b0;
            ie_q <= 2'b00; ev_wr_q <= 1'b0; ev_pr_q <= 1'b0; err_addr_q <= '0;
        end else begin
            if (wr_cfg && cfg_addr == A_CTRL) begin
                lock_q  <= lock_q | cfg_wdata[0];
                ponly_q <= cfg_wdata[1];
            end
            if (wr && cfg_addr == A_IEN) ie_q <= cfg_wdata[1:0];
            cflag_q <= (cflag_q & ~clr[0]) | (cfg_req & ~priv_ok);
            bflag_q <= (bflag_q & ~clr[1]) | bus_evt;
            if (bus_evt && (!bflag_q || clr[1])) begin
                err_addr_q <= evt_addr;
                ev_wr_q    <= evt_write;
                ev_pr_q    <= evt_priv;
            end
        end
    end

    // Window registers with the enable, freeze and bound-order rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcfg_q <= '0; lo_q <= '0; hi_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_cfg && rsel[i]) begin
                    case (cfg_addr[3:2])
                        2'd0: begin
                            rcfg_q[i].priv <= cfg_wdata[4];
                            if (!rcfg_q[i].en) begin
                                rcfg_q[i].enc <= enc_e'(cfg_wdata[9:8]);
                                rcfg_q[i].ctx <= cfg_wdata[13:12];
                                rcfg_q[i].en  <= cfg_wdata[0] && (lo_q[i] <= hi_q[i]);
                            end else begin
                                rcfg_q[i].en  <= cfg_wdata[0];
                            end
                        end
                        2'd1: if (!rcfg_q[i].en) lo_q[i] <= cfg_wdata[PLO +: PW];
                        2'd2: if (!rcfg_q[i].en) hi_q[i] <= cfg_wdata[PLO +: PW];
                        default: rcfg_q[i].wren <= cfg_wdata[0];
                    endcase
                end
            end
        end
    end

    // Read mux; wrong-privilege or write cycles return zero.
    always_comb begin
        cfg_rdata = '0;
        if (acc_ok && !cfg_we) begin
            case (cfg_addr)
                A_CTRL: cfg_rdata[1:0] = {ponly_q, lock_q};
                A_FLAG: cfg_rdata[1:0] = {bflag_q, cflag_q};
                A_IEN:  cfg_rdata[1:0] = ie_q;
                A_INFO: cfg_rdata[1:0] = {ev_pr_q, ev_wr_q};
                A_EADR: cfg_rdata      = err_addr_q;
                default: ;
            endcase
            for (int i = 0; i < NREG; i++) begin
                if (rsel[i]) begin
                    case (cfg_addr[3:2])
                        2'd0: begin
                            cfg_rdata[0]     = rcfg_q[i].en;
                            cfg_rdata[4]     = rcfg_q[i].priv;
                            cfg_rdata[9:8]   = rcfg_q[i].enc;
                            cfg_rdata[13:12] = rcfg_q[i].ctx;
                        end
                        2'd1: cfg_rdata[PLO +: PW] = lo_q[i];
                        2'd2: begin
                            cfg_rdata[PLO +: PW]  = hi_q[i];
                            cfg_rdata[PLO-1:0]    = '1;
                        end
                        default: cfg_rdata[0] = rcfg_q[i].wren;
                    endcase
                end
            end
        end
    end

    assign rcfg_o     = rcfg_q;
    assign lo_o       = lo_q;
    assign hi_o       = hi_q;
    assign irq        = |(ie_q & {bflag_q, cflag_q});
    assign lock_o     = lock_q;
    assign bus_flag_o = bflag_q;
    assign bus_clr_o  = clr[1];
    assign err_addr_o = err_addr_q;
endmodule

// File: rtl/rgn_guard.sv
// Top of the address region security filter: page compare per window,
// resolution, one register stage on the decision, and the register file.
// Assumes PLO+PW <= AW and NCTX <= 3.
module rgn_guard
    import rgn_pkg::*;
#(
    parameter int NREG = 4,
    parameter int NCTX = 2,
    parameter int AW   = 32,
    parameter int PLO  = 12,
    parameter int PW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_req,
    input  logic            cfg_we,
    input  logic [7:0]      cfg_addr,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            cfg_priv,
    output logic [AW-1:0]   cfg_rdata,
    input  logic            key_main_ok,
    input  logic            key_fast_ok,
    input  logic [NCTX-1:0] ctx_ok,
    input  logic            cipher_off,
    input  logic            acc_valid,
    input  logic [AW-1:0]   acc_addr,
    input  logic            acc_write,
    input  logic            acc_priv,
    output logic            dec_valid,
    output logic            dec_grant,
    output logic [1:0]      dec_mode,
    output logic [CTX_W-1:0] dec_ctx,
    output logic            irq
);
    rgn_cfg_t [NREG-1:0]     rcfg_w;
    logic [NREG-1:0][PW-1:0] lo_w, hi_w;
    logic [NREG-1:0]         hit_w, en_w;
    logic                    grant_w, viol_w, bus_evt;
    enc_e                    mode_w;
    logic [CTX_W-1:0]        ctx_w;
    logic                    lock_w, bus_flag_w, bus_clr_w;
    logic [AW-1:0]           err_addr_w;

    for (genvar g = 0; g < NREG; g++) begin : g_win
        assign en_w[g] = rcfg_w[g].en;
        rgn_match #(.PW(PW)) u_match (
            .en(en_w[g]), .page(acc_addr[PLO +: PW]),
            .lo(lo_w[g]), .hi(hi_w[g]), .hit(hit_w[g])
        );
    end

    rgn_resolve #(.NREG(NREG), .NCTX(NCTX)) u_resolve (
        .hit(hit_w), .rcfg(rcfg_w), .acc_write(acc_write), .acc_priv(acc_priv),
        .key_main_ok(key_main_ok), .key_fast_ok(key_fast_ok), .ctx_ok(ctx_ok),
        .cipher_off(cipher_off), .grant(grant_w), .viol(viol_w),
        .mode(mode_w), .ctx(ctx_w)
    );

    assign bus_evt = acc_valid && viol_w;

    rgn_regs #(.NREG(NREG), .AW(AW), .PLO(PLO), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv),
        .cfg_rdata(cfg_rdata), .bus_evt(bus_evt), .evt_addr(acc_addr),
        .evt_write(acc_write), .evt_priv(acc_priv), .rcfg_o(rcfg_w),
        .lo_o(lo_w), .hi_o(hi_w), .irq(irq), .lock_o(lock_w),
        .bus_flag_o(bus_flag_w), .bus_clr_o(bus_clr_w), .err_addr_o(err_addr_w)
    );

    // Register the decision one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0; dec_grant <= 1'b0; dec_mode <= 2'b00; dec_ctx <= '0;
        end else begin
            dec_valid <= acc_valid;
            dec_grant <= acc_valid && grant_w;
            dec_mode  <= acc_valid ? mode_w : ENC_NONE;
            dec_ctx   <= acc_valid ? ctx_w : '0;
        end
    end
endmodule

// File: rtl/rgn_guard_chk.sv
// Property checker for rgn_guard, attached with bind below.
module rgn_guard_chk #(
    parameter int NREG = 4,
    parameter int AW   = 32,
    parameter int PW   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic                    dec_valid,
    input logic                    dec_grant,
    input logic [1:0]              dec_mode,
    input logic [1:0]              dec_ctx,
    input logic                    lock,
    input logic                    bus_flag,
    input logic                    bus_clr,
    input logic [AW-1:0]           err_addr,
    input logic [NREG-1:0]         en_vec,
    input logic [NREG-1:0][PW-1:0] lo,
    input logic [NREG-1:0][PW-1:0] hi
);
    // R13
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> dec_valid);
    // R13
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !dec_valid);
    // R6
    deny_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_grant) |-> (dec_mode == 2'b00 && dec_ctx == 2'b00));
    // R7
    stream_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_mode == 2'b01) |-> (dec_ctx != 2'b00));
    // R7
    ctx_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ctx != 2'b11);
    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
    // R10
    record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_flag && !bus_clr) |=> $stable(err_addr));
    for (genvar g = 0; g < NREG; g++) begin : g_ord
        // R3
        bound_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            en_vec[g] |-> (lo[g] <= hi[g]));
    end
endmodule

bind rgn_guard rgn_guard_chk #(.NREG(NREG), .AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .dec_valid(dec_valid),
    .dec_grant(dec_grant), .dec_mode(dec_mode), .dec_ctx(dec_ctx),
    .lock(lock_w), .bus_flag(bus_flag_w), .bus_clr(bus_clr_w),
    .err_addr(err_addr_w), .en_vec(en_w), .lo(lo_w), .hi(hi_w)
);

// File: tb/rgn_guard_bench.sv
// Self-checking bench for rgn_guard: a vector table walked by one loop,
// then directed tests for reset, bounds, overlap, fallback, freeze and lock.
module rgn_guard_bench;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_req = 0, cfg_we = 0, cfg_priv = 1;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        key_main_ok = 1, key_fast_ok = 0, cipher_off = 0;
    logic [1:0]  ctx_ok = 2'b01;
    logic        acc_valid = 0, acc_write = 0, acc_priv = 0;
    logic [31:0] acc_addr = '0;
    logic        dec_valid, dec_grant, irq;
    logic [1:0]  dec_mode, dec_ctx;
    int          checks = 0, failures = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    rgn_guard u_rgn_guard (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv),
        .cfg_rdata(cfg_rdata), .key_main_ok(key_main_ok), .key_fast_ok(key_fast_ok),
        .ctx_ok(ctx_ok), .cipher_off(cipher_off), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
        .dec_valid(dec_valid), .dec_grant(dec_grant), .dec_mode(dec_mode),
        .dec_ctx(dec_ctx), .irq(irq)
    );

    // {addr, write, priv, exp_grant, exp_mode, exp_ctx}
    localparam logic [38:0] VEC [11] = '{
        {32'h0001_0000, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00}, // R1 low bound of window 0
        {32'h0001_1FFF, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00}, // R1 write inside window 0
        {32'h0001_2000, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00}, // R5 R6 encrypted window rules, unpriv denied
        {32'h0001_2000, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00}, // R5 R7 block with main key
        {32'hF001_3FFF, 1'b1, 1'b1, 1'b1, 2'b10, 2'b00}, // R1 top nibble ignored
        {32'h0001_8FFF, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00}, // R1 high bound of window 1
        {32'h0001_9000, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00}, // R4 one page past window 1
        {32'h0002_0010, 1'b0, 1'b0, 1'b1, 2'b01, 2'b01}, // R7 stream on context 1
        {32'h0002_1000, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00}, // R6 write to read-only window
        {32'h0003_0800, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00}, // R7 fast key invalid -> bypass
        {32'h000F_0000, 1'b1, 1'b0, 1'b1, 2'b00, 2'b00}  // R4 default region write
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d, input logic p = 1'b1);
        @(negedge clk);
        cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d; cfg_priv = p;
        @(negedge clk);
        cfg_req = 0; cfg_we = 0; cfg_priv = 1;
    endtask

    task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d, input logic p = 1'b1);
        @(negedge clk);
        cfg_req = 1; cfg_we = 0; cfg_addr = a; cfg_priv = p;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_req = 0; cfg_priv = 1;
    endtask

    task automatic access(input logic [31:0] a, input logic w, input logic p);
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_write = w; acc_priv = p;
        @(negedge clk);
        acc_valid = 0;
    endtask

    function automatic logic [31:0] ctrlw(input logic en, input logic pr,
                                          input logic [1:0] enc, input logic [1:0] cx);
        return {18'd0, cx, 2'b00, enc, 3'b000, pr, 3'b000, en};
    endfunction

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R13 reset dec_valid", {31'd0, dec_valid}, 32'd0);
        chk("R11 reset irq", {31'd0, irq}, 32'd0);
        cfg_rd(8'h28, rd); chk("R2 reset end", rd, 32'h0000_0FFF);
        cfg_rd(8'h24, rd); chk("R2 reset start", rd, 32'h0);

        cfg_wr(8'h24, 32'hFFFF_FFFF); cfg_rd(8'h24, rd); chk("R2 start readback", rd, 32'h0FFF_F000);
        cfg_wr(8'h28, 32'h1234_5678); cfg_rd(8'h28, rd); chk("R2 end readback", rd, 32'h0234_5FFF);

        cfg_wr(8'h24, 32'h0000_5000); cfg_wr(8'h28, 32'h0000_4FFF);
        cfg_wr(8'h20, ctrlw(1, 0, 2'b00, 2'b00));
        cfg_rd(8'h20, rd); chk("R3 enable refused", rd, 32'h0);

        // Table configuration
        cfg_wr(8'h24, 32'h0001_0000); cfg_wr(8'h28, 32'h0001_3FFF);
        cfg_wr(8'h2C, 32'h1); cfg_wr(8'h20, ctrlw(1, 0, 2'b00, 2'b00));
        cfg_wr(8'h34, 32'h0001_2000); cfg_wr(8'h38, 32'h0001_8FFF);
        cfg_wr(8'h3C, 32'h1); cfg_wr(8'h30, ctrlw(1, 1, 2'b10, 2'b00));
        cfg_wr(8'h44, 32'h0002_0000); cfg_wr(8'h48, 32'h0002_1FFF);
        cfg_wr(8'h4C, 32'h0); cfg_wr(8'h40, ctrlw(1, 0, 2'b01, 2'b01));
        cfg_wr(8'h54, 32'h0003_0000); cfg_wr(8'h58, 32'h0003_0FFF);
        cfg_wr(8'h5C, 32'h1); cfg_wr(8'h50, ctrlw(1, 0, 2'b11, 2'b00));

        for (int i = 0; i < 11; i++) begin
            access(VEC[i][38:7], VEC[i][6], VEC[i][5]);
            chk($sformatf("table[%0d] grant", i), {31'd0, dec_grant}, {31'd0, VEC[i][4]});
            chk($sformatf("table[%0d] mode", i), {30'd0, dec_mode}, {30'd0, VEC[i][3:2]});
            chk($sformatf("table[%0d] ctx", i), {30'd0, dec_ctx}, {30'd0, VEC[i][1:0]});
        end

        // R10 first violation kept, second ignored
        cfg_rd(8'h14, rd); chk("R10 record addr", rd, 32'h0001_2000);
        cfg_rd(8'h10, rd); chk("R10 record info", rd, 32'h0);
        cfg_rd(8'h04, rd); chk("R10 bus flag", rd, 32'h2);
        cfg_wr(8'h08, 32'h2); cfg_rd(8'h04, rd); chk("R11 clear bus flag", rd, 32'h0);
        access(32'h0002_1000, 1, 0);
        cfg_rd(8'h14, rd); chk("R10 new record addr", rd, 32'h0002_1000);
        cfg_rd(8'h10, rd); chk("R10 new record info", rd, 32'h1);

        // R8 frozen fields while enabled
        cfg_wr(8'h30, ctrlw(1, 0, 2'b01, 2'b00));
        cfg_rd(8'h30, rd); chk("R8 ctrl cipher frozen, priv changed", rd, 32'h0000_0201);
        cfg_wr(8'h34, 32'h0005_0000);
        cfg_rd(8'h34, rd); chk("R8 start frozen", rd, 32'h0001_2000);
        access(32'h0001_2000, 0, 0);
        chk("R8 unpriv now granted", {29'd0, dec_grant, dec_mode}, {29'd0, 1'b1, 2'b10});

        // R7 fallbacks
        key_main_ok = 0;
        access(32'h0001_8000, 0, 1);
        chk("R7 main key invalid", {29'd0, dec_grant, dec_mode}, {29'd0, 1'b1, 2'b00});
        key_main_ok = 1; ctx_ok = 2'b00;
        access(32'h0002_0010, 0, 0);
        chk("R7 context disabled", {27'd0, dec_grant, dec_mode, dec_ctx}, {27'd0, 1'b1, 4'b0000});
        ctx_ok = 2'b01;

        // R5 two encrypted windows overlapping
        cfg_wr(8'h50, ctrlw(0, 0, 2'b11, 2'b00));
        cfg_wr(8'h54, 32'h0001_2000); cfg_wr(8'h58, 32'h0001_2FFF);
        cfg_wr(8'h50, ctrlw(1, 0, 2'b11, 2'b00));
        key_fast_ok = 1;
        access(32'h0001_2000, 0, 1);
        chk("R5 encrypted overlap rejected", {31'd0, dec_grant}, 32'd0);
        // R5 unencrypted overlap: lowest index rules
        cfg_wr(8'h50, ctrlw(0, 0, 2'b00, 2'b00));
        cfg_wr(8'h54, 32'h0001_0000); cfg_wr(8'h58, 32'h0001_0FFF);
        cfg_wr(8'h5C, 32'h0); cfg_wr(8'h50, ctrlw(1, 0, 2'b00, 2'b00));
        access(32'h0001_0000, 1, 0);
        chk("R5 lowest index rules", {31'd0, dec_grant}, 32'd1);

        // R12 encryption disabled
        cipher_off = 1;
        access(32'h0001_8000, 0, 1);
        chk("R12 encrypted window denied", {31'd0, dec_grant}, 32'd0);
        access(32'h0001_9000, 0, 0);
        chk("R12 default region granted", {31'd0, dec_grant}, 32'd1);
        cipher_off = 0;

        // R13 decision appears one cycle later
        @(negedge clk);
        acc_valid = 1; acc_addr = 32'h000F_0000; acc_write = 0; acc_priv = 0;
        #1 chk("R13 not before edge", {31'd0, dec_valid}, 32'd0);
        @(negedge clk);
        acc_valid = 0;
        chk("R13 valid after edge", {31'd0, dec_valid}, 32'd1);
        @(negedge clk);
        chk("R13 idle after", {31'd0, dec_valid}, 32'd0);

        // R11 interrupt combine and config privilege error
        chk("R11 irq masked", {31'd0, irq}, 32'd0);
        cfg_wr(8'h0C, 32'h2); @(negedge clk);
        chk("R11 irq bus", {31'd0, irq}, 32'd1);
        cfg_wr(8'h08, 32'h2); @(negedge clk);
        chk("R11 irq cleared", {31'd0, irq}, 32'd0);
        cfg_wr(8'h00, 32'h2);
        cfg_rd(8'h0C, rd, 1'b0); chk("R11 unpriv read zero", rd, 32'h0);
        cfg_rd(8'h04, rd); chk("R11 config flag", rd, 32'h1);
        cfg_wr(8'h0C, 32'h1); @(negedge clk);
        chk("R11 irq config", {31'd0, irq}, 32'd1);
        cfg_wr(8'h08, 32'h1); @(negedge clk);
        chk("R11 config cleared", {31'd0, irq}, 32'd0);

        // R9 lock
        cfg_wr(8'h00, 32'h3);
        cfg_rd(8'h00, rd); chk("R9 lock set", rd, 32'h3);
        cfg_wr(8'h2C, 32'h0);
        cfg_rd(8'h2C, rd); chk("R9 attr write ignored", rd, 32'h1);
        cfg_wr(8'h00, 32'h0);
        cfg_rd(8'h00, rd); chk("R9 lock stays", rd, 32'h3);
        cfg_wr(8'h0C, 32'h3);
        cfg_rd(8'h0C, rd); chk("R9 irq enable writable", rd, 32'h3);
        cfg_rd(8'h0C, rd, 1'b0);
        cfg_wr(8'h08, 32'h1);
        cfg_rd(8'h04, rd); chk("R9 clear writable", rd, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule